// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the digital control half of a clock generator that has three possible sources: an internal reference, an external reference from a crystal oscillator, and the output of a frequency-locked loop (FLL). Firmware programs a small register file over a simple address/data bus. The block turns those settings into a clock-mux select, an FLL reference select, an internal-reference enable, a reference divider value and an FLL multiplier code. The oscillator, the loop and the DCO are outside the block. The only thing it sees from them is an oscillator-ready level.

A requested setting does not reach the mux at once. If the oscillator is enabled and the new setting needs the external reference, the block holds the previous source until the synchronised oscillator-ready flag is set. After a setting is applied, its status copy passes through a synchroniser pipeline that models the handover of a glitch-free mux. Firmware therefore knows a mode change is finished only when the status register shows the requested source and reference.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: During and after reset, the source-control register (address 0) reads 0x04, the auxiliary register (address 1) reads 0x00, the status register (address 2) reads 0x02, the mux select is 2'b00 and the FLL reference select is 1.
- R2: Address 0 bits [7:6] pick the system clock source: 2'b00 is the FLL output, 2'b01 is the internal reference and 2'b10 is the external reference. A write of 2'b11 leaves the previous source in force, while the other fields of that write still take effect.
- R3: Status bits [3:2] report the applied mux select exactly two clock cycles after the mux select output changes, and never earlier.
- R4: Status bit [1] reports the applied FLL reference (1 = internal), with the same two-cycle lag after the reference-select output changes. Address 0 bit [2] requests it.
- R5: When the oscillator enable (address 1 bit [0]) is set, a request that needs the external reference (source 2'b10, or reference bit clear) changes neither output until the oscillator-init flag is set. That flag is status bit [0], and it equals the enable AND the oscillator-ready input delayed through two flops. The outputs change one cycle after the flag rises.
- R6: When the oscillator enable is clear, every request is applied on the clock after the write.
- R7: The internal-reference enable output is high when the applied reference is internal, or the applied source is 2'b01, or the keep-alive bit (address 0 bit [1]) is set. Otherwise it is low.
- R8: The multiplier output is 640 × (range + 1), where range is address 1 bits [2:1]. This gives 640, 1280, 1920 and 2560.
- R9: The reference-divider output equals address 0 bits [5:3].
- R10: The status register is read-only. Writes to address 2 change no register and no output.
- R11: A request for the internal reference with a source other than 2'b10 is applied on the next clock, even while the oscillator is enabled but not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| osc_ready_i | input | 1 | Oscillator-stable level from the analog oscillator |
| clk_mux_sel_o | output | 2 | Applied system clock source select |
| fll_ref_int_o | output | 1 | Applied FLL reference select, 1 = internal |
| irc_en_o | output | 1 | Internal reference enable |
| ref_div_o | output | 3 | External reference divider code |
| fll_mult_o | output | 12 | FLL multiplier value |

## Verification
The hardest state to reach is a pending external-reference request that is held back by an enabled oscillator that is not ready. In that state the mux, the reference select and the status must all keep their old values, and then each must move on its own exact cycle after the ready level rises. The stimulus sets the oscillator enable first, requests the external source while holding the ready input low for many cycles, and then raises it at a known falling edge. It samples the mux and status on each edge that follows. A second directed case drops the ready level again and checks that a return to the internal reference is not held back.

// File: rtl/csm_pkg.sv
package csm_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 3;
  localparam int RNG_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_SRC  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_AUX  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;

  typedef enum logic [1:0] {
    SRC_FLL = 2'b00,
    SRC_INT = 2'b01,
    SRC_EXT = 2'b10,
    SRC_RSV = 2'b11
  } src_e;

  typedef struct packed {
    src_e             src;
    logic [DIV_W-1:0] div;
    logic             ref_int;
    logic             irc_keep;
    logic             osc_en;
    logic [RNG_W-1:0] range;
  } ctrl_t;

  typedef struct packed {
    src_e src;
    logic ref_int;
  } sel_t;

  localparam ctrl_t CTRL_RST = '{src: SRC_FLL, div: '0, ref_int: 1'b1,
                                 irc_keep: 1'b0, osc_en: 1'b0, range: '0};
  localparam sel_t  SEL_RST  = '{src: SRC_FLL, ref_int: 1'b1};

endpackage

// File: rtl/csm_sync.sv
module csm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/csm_regs.sv
module csm_regs
  import csm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  sel_t              stat_sel,
  input  logic              osc_init,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  ctrl_en;
  src_e  wr_src;

  assign wr_src  = src_e'(wdata[7:6]);
  assign ctrl_en = we && ((addr == ADR_SRC) || (addr == ADR_AUX));

  // next-state: reserved source code keeps the old selection
  always_comb begin
    ctrl_d = ctrl_q;
    if (addr == ADR_SRC) begin
      if (wr_src != SRC_RSV) ctrl_d.src = wr_src;
      ctrl_d.div      = wdata[5:3];
      ctrl_d.ref_int  = wdata[2];
      ctrl_d.irc_keep = wdata[1];
    end else if (addr == ADR_AUX) begin
      ctrl_d.range  = wdata[2:1];
      ctrl_d.osc_en = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_SRC:  rdata = {ctrl_q.src, ctrl_q.div, ctrl_q.ref_int, ctrl_q.irc_keep, 1'b0};
      ADR_AUX:  rdata = {5'b0, ctrl_q.range, ctrl_q.osc_en};
      ADR_STAT: rdata = {4'b0, stat_sel.src, stat_sel.ref_int, osc_init};
      default:  rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/csm_switch.sv
module csm_switch
  import csm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  osc_init,
  output sel_t  applied,
  output sel_t  stat_sel
);

  sel_t app_q;
  sel_t app_d;
  logic ext_needed;
  logic app_en;
  sel_t pipe_q [STAGES];
  sel_t pipe_d [STAGES];

  assign ext_needed = (ctrl.src == SRC_EXT) || !ctrl.ref_int;
  assign app_en     = !ext_needed || !ctrl.osc_en || osc_init;

  always_comb begin
    app_d.src     = ctrl.src;
    app_d.ref_int = ctrl.ref_int;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      app_q <= SEL_RST;
    else if (app_en) app_q <= app_d;
  end

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_pipe
      if (i == 0) begin : g_first
        assign pipe_d[i] = app_q;
      end else begin : g_next
        assign pipe_d[i] = pipe_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[i] <= SEL_RST;
        else        pipe_q[i] <= pipe_d[i];
      end
    end
  endgenerate

  assign applied  = app_q;
  assign stat_sel = pipe_q[STAGES-1];

endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
  import csm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MULT_W      = 12,
  parameter int BASE_MULT   = 640
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              osc_ready_i,
  output logic [1:0]        clk_mux_sel_o,
  output logic              fll_ref_int_o,
  output logic              irc_en_o,
  output logic [DIV_W-1:0]  ref_div_o,
  output logic [MULT_W-1:0] fll_mult_o
);

  localparam logic [MULT_W-1:0] BASE_M = MULT_W'(BASE_MULT);

  logic  rst_n_int;
  logic  osc_rdy_sync;
  logic  osc_init;
  ctrl_t ctrl;
  sel_t  applied;
  sel_t  stat_sel;
  logic [1:0] stat_src;
  logic       stat_ref;

  csm_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk_i), .rst_n(rst_ni), .d(1'b1), .q(rst_n_int)
  );

  csm_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk(clk_i), .rst_n(rst_n_int), .d(osc_ready_i), .q(osc_rdy_sync)
  );

  assign osc_init = ctrl.osc_en && osc_rdy_sync;

  csm_regs u_regs (
    .clk(clk_i), .rst_n(rst_n_int), .addr(bus_addr_i), .we(bus_we_i),
    .wdata(bus_wdata_i), .stat_sel(stat_sel), .osc_init(osc_init),
    .ctrl(ctrl), .rdata(bus_rdata_o)
  );

  csm_switch #(.STAGES(SYNC_STAGES)) u_switch (
    .clk(clk_i), .rst_n(rst_n_int), .ctrl(ctrl), .osc_init(osc_init),
    .applied(applied), .stat_sel(stat_sel)
  );

  assign stat_src      = stat_sel.src;
  assign stat_ref      = stat_sel.ref_int;
  assign clk_mux_sel_o = applied.src;
  assign fll_ref_int_o = applied.ref_int;
  assign irc_en_o      = applied.ref_int || (applied.src == SRC_INT) || ctrl.irc_keep;
  assign ref_div_o     = ctrl.div;
  assign fll_mult_o    = (MULT_W'(ctrl.range) + MULT_W'(1)) * BASE_M;

endmodule

// File: rtl/csm_chk.sv
module csm_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rst_ni,
  input logic [1:0]  mux_sel,
  input logic        ref_int,
  input logic        irc_en,
  input logic [1:0]  stat_src,
  input logic        stat_ref,
  input logic        osc_en,
  input logic        osc_init,
  input logic [11:0] fll_mult
);

  localparam int SETTLE = SYNC_STAGES + 4;

  logic [7:0] age_q;
  logic       settled;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                 age_q <= '0;
    else if (age_q < 8'(SETTLE)) age_q <= age_q + 8'd1;
  end

  assign settled = (age_q >= 8'(SETTLE));

  // R3
  stat_src_lag_chk: assert property (@(posedge clk) disable iff (!rst_ni || !settled)
    stat_src == $past(mux_sel, SYNC_STAGES));

  // R4
  stat_ref_lag_chk: assert property (@(posedge clk) disable iff (!rst_ni || !settled)
    stat_ref == $past(ref_int, SYNC_STAGES));

  // R5
  ext_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni || !settled)
    (osc_en && !osc_init && mux_sel != 2'b10) |=> (mux_sel != 2'b10));

  // R5
  ext_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni || !settled)
    (osc_en && !osc_init && ref_int) |=> ref_int);

  // R2
  no_rsv_sel_chk: assert property (@(posedge clk) disable iff (!rst_ni || !settled)
    mux_sel != 2'b11);

  // R7
  irc_on_chk: assert property (@(posedge clk) disable iff (!rst_ni || !settled)
    (ref_int || mux_sel == 2'b01) |-> irc_en);

  // R8
  mult_legal_chk: assert property (@(posedge clk) disable iff (!rst_ni || !settled)
    (fll_mult == 12'd640) || (fll_mult == 12'd1280) ||
    (fll_mult == 12'd1920) || (fll_mult == 12'd2560));

endmodule

bind clksrc_mode_ctrl csm_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk_i), .rst_ni(rst_ni), .mux_sel(clk_mux_sel_o), .ref_int(fll_ref_int_o),
  .irc_en(irc_en_o), .stat_src(stat_src), .stat_ref(stat_ref),
  .osc_en(ctrl.osc_en), .osc_init(osc_init), .fll_mult(fll_mult_o)
);

// File: tb/sim_clksrc_mode_ctrl.sv
module sim_clksrc_mode_ctrl;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        osc_ready_i = 1'b0;
  logic [1:0]  clk_mux_sel_o;
  logic        fll_ref_int_o;
  logic        irc_en_o;
  logic [2:0]  ref_div_o;
  logic [11:0] fll_mult_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {wdata, exp_mux, exp_ref, exp_irc, exp_status, exp_div}
  localparam logic [22:0] VEC [0:4] = '{
    {8'h98, 2'b10, 1'b0, 1'b0, 8'h08, 3'd3},
    {8'h2A, 2'b00, 1'b0, 1'b1, 8'h00, 3'd5},
    {8'h44, 2'b01, 1'b1, 1'b1, 8'h06, 3'd0},
    {8'hF8, 2'b01, 1'b0, 1'b1, 8'h04, 3'd7},
    {8'h04, 2'b00, 1'b1, 1'b1, 8'h02, 3'd0}
  };

  clksrc_mode_ctrl u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(4);

    // R1 reset state
    rd(2'd0, rv); chk("R1 src reg", rv, 8'h04);
    rd(2'd1, rv); chk("R1 aux reg", rv, 8'h00);
    rd(2'd2, rv); chk("R1 status", rv, 8'h02);
    chk("R1 mux", clk_mux_sel_o, 2'b00);
    chk("R1 ref", fll_ref_int_o, 1'b1);

    // table walk, oscillator disabled: R2 R4 R6 R7 R9 R3
    foreach (VEC[i]) begin
      wr(2'd0, VEC[i][22:15]);
      idle(8);
      chk("R2 R6 mux", clk_mux_sel_o, VEC[i][14:13]);
      chk("R4 ref", fll_ref_int_o, VEC[i][12]);
      chk("R7 irc", irc_en_o, VEC[i][11]);
      rd(2'd2, rv); chk("R3 status", rv, VEC[i][10:3]);
      chk("R9 div", ref_div_o, VEC[i][2:0]);
    end

    // R8 multiplier per range code
    for (int r = 0; r < 4; r++) begin
      wr(2'd1, 8'(r << 1));
      chk("R8 mult", fll_mult_o, 32'((r + 1) * 640));
    end

    // R10 status register read-only
    wr(2'd2, 8'hFF);
    idle(4);
    rd(2'd2, rv); chk("R10 status", rv, 8'h02);
    rd(2'd0, rv); chk("R10 src reg", rv, 8'h04);
    chk("R10 mux", clk_mux_sel_o, 2'b00);

    // R5 oscillator gating
    wr(2'd1, 8'h01);
    rd(2'd2, rv); chk("R5 init low", rv, 8'h02);
    wr(2'd0, 8'h98);
    idle(10);
    chk("R5 mux held", clk_mux_sel_o, 2'b00);
    chk("R5 ref held", fll_ref_int_o, 1'b1);
    rd(2'd2, rv); chk("R5 status held", rv, 8'h02);
    osc_ready_i = 1'b1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R5 mux before", clk_mux_sel_o, 2'b00);
    rd(2'd2, rv); chk("R5 init set", rv, 8'h03);
    @(posedge clk_i); @(negedge clk_i);
    chk("R5 mux switched", clk_mux_sel_o, 2'b10);
    chk("R7 irc off", irc_en_o, 1'b0);
    rd(2'd2, rv); chk("R3 status lag", rv, 8'h03);
    @(posedge clk_i); @(negedge clk_i);
    rd(2'd2, rv); chk("R3 status lag2", rv, 8'h03);
    @(posedge clk_i); @(negedge clk_i);
    rd(2'd2, rv); chk("R3 R4 status done", rv, 8'h09);

    // R11 return to internal while oscillator not ready
    osc_ready_i = 1'b0;
    idle(4);
    rd(2'd2, rv); chk("R11 init low", rv, 8'h08);
    wr(2'd0, 8'h04);
    @(posedge clk_i); @(negedge clk_i);
    chk("R11 mux", clk_mux_sel_o, 2'b00);
    chk("R11 ref", fll_ref_int_o, 1'b1);

    // R1 reset in mid-operation
    wr(2'd0, 8'h9A);
    idle(3);
    rst_ni = 1'b0;
    #1;
    rd(2'd0, rv); chk("R1 rst src reg", rv, 8'h04);
    rd(2'd1, rv); chk("R1 rst aux reg", rv, 8'h00);
    chk("R1 rst mux", clk_mux_sel_o, 2'b00);
    idle(2);
    rst_ni = 1'b1;
    idle(4);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule